// File: doc/BRIEF.md
# Trace differential timestamp generator

This block decides when a software trace stream needs a differential timestamp and supplies the value. A prescaled elapsed counter measures the time since the last timestamp. Whenever a timestamp is emitted, the block presents a one-cycle valid pulse with the elapsed count, and then it restarts its counters. Three conditions trigger an emission. The first is a packet write while the elapsed count is non-zero. The second is the elapsed counter reaching its limit. The third is a long stretch with no trace activity.

A small control register holds the settings. It has a master trace enable, a timestamp enable, a mode bit that selects triggering by trace-bus activity, and a two-bit prescale code. The register accepts writes only when a privilege qualifier comes with the write. A busy flag shows that accepted traffic is still draining downstream.

Top module: `trace_ts_gen`

## Requirements
- R1: After reset, `cfg_rdata_o`, `ts_valid_o`, `ts_delta_o`, `ts_ovf_o` and `busy_o` are all zero, so timestamping is off.
- R2: A control write (`cfg_we_i`) takes effect only if `cfg_priv_i` is high in the same cycle. Otherwise the value read back on `cfg_rdata_o` stays unchanged. The field layout is: bit 0 trace enable, bit 1 timestamp enable, bit 2 bus-activity mode, bits 5:4 prescale code. All other bits read as 0.
- R3: The elapsed count advances once every 1, 4, 16 or 64 cycles for prescale codes 0, 1, 2 and 3.
- R4: Timestamping is active when both enables are set and the mode bit is clear. In that state, a `pkt_wr_i` in a cycle where the elapsed count is non-zero produces `ts_valid_o` in the next cycle, carrying that count. If the count is zero, nothing is emitted.
- R5: An elapsed-count advance while the count is all ones produces one emission with `ts_delta_o` all ones and `ts_ovf_o` = 1, even if a packet write occurs in the same cycle.
- R6: Outside bus-activity mode, an emission occurs after IDLE_LIMIT cycles with no emission and no packet write.
- R7: In bus-activity mode, `bus_act_i` takes the place of `pkt_wr_i` as the trigger (the count must still be non-zero), `pkt_wr_i` never causes an emission, and no idle emission occurs.
- R8: While either enable is clear, no timestamp is emitted, and the counters are held at zero.
- R9: After each emission, the elapsed and idle counts restart from zero, so `ts_valid_o` is never high on two consecutive cycles.
- R10: A write that changes the prescale code clears the divider, so the first advance after the change follows the new ratio.
- R11: A packet write accepted under the trace enable, or any emission, holds `busy_o` high for the next DRAIN_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_priv_i | input | 1 | Privilege qualifier for the write |
| cfg_wdata_i | input | CFG_W | Control write data |
| cfg_rdata_o | output | CFG_W | Control register readback |
| pkt_wr_i | input | 1 | Packet written to the trace buffer |
| bus_act_i | input | 1 | Activity on the internal trace bus |
| ts_valid_o | output | 1 | Timestamp emitted (one-cycle pulse) |
| ts_delta_o | output | CNT_W | Elapsed count carried by the timestamp |
| ts_ovf_o | output | 1 | Timestamp caused by counter overflow |
| busy_o | output | 1 | Trace events still draining |

## Verification
Directed runs cover each trigger on its own. The idle interval is measured under prescale codes 1 to 3, and because the reported count differs for each code, the divider ratio is exposed. A free-running count with no packets isolates overflow, and its saturated value shows up against the idle path. A packet with a zero count, and packets in bus-activity mode, tell the count-gated packet rule apart from the alternative trigger. Constrained random traffic then mixes packets, bus activity and privileged and unprivileged reconfiguration, including prescale changes in the middle of a count. This traffic is compared cycle by cycle against a model built from the requirements, which catches ordering faults between coincident triggers.

// File: rtl/trace_ts_pkg.sv
package trace_ts_pkg;

  localparam int unsigned CFG_FIELD_W = 6;
  localparam int unsigned DIV_W       = 6;

  typedef struct packed {
    logic [1:0] presc;
    logic       bus_mode;
    logic       ts_en;
    logic       trace_en;
  } cfg_t;

  function automatic cfg_t cfg_from_bits(logic [CFG_FIELD_W-1:0] b);
    cfg_t c;
    c.trace_en = b[0];
    c.ts_en    = b[1];
    c.bus_mode = b[2];
    c.presc    = b[5:4];
    return c;
  endfunction

  function automatic logic [CFG_FIELD_W-1:0] cfg_to_bits(cfg_t c);
    logic [CFG_FIELD_W-1:0] b;
    b    = '0;
    b[0] = c.trace_en;
    b[1] = c.ts_en;
    b[2] = c.bus_mode;
    b[5:4] = c.presc;
    return b;
  endfunction

  // terminal divider value: ratio 4^code minus one
  function automatic logic [DIV_W-1:0] presc_last(logic [1:0] code);
    logic [DIV_W-1:0] r;
    r = DIV_W'((32'd1 << (2 * code)) - 32'd1);
    return r;
  endfunction

endpackage

// File: rtl/trace_ts_cfg.sv
module trace_ts_cfg
  import trace_ts_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             priv_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [CFG_W-1:0] rdata_o,
  output logic             presc_clr_o
);

  cfg_t cfg_q;
  cfg_t cfg_d;
  logic wr_ok;

  assign wr_ok = we_i & priv_i;
  assign cfg_d = cfg_from_bits(wdata_i[CFG_FIELD_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (wr_ok) cfg_q <= cfg_d;
  end

  assign presc_clr_o = wr_ok && (cfg_d.presc != cfg_q.presc);
  assign cfg_o       = cfg_q;

  generate
    if (CFG_W > CFG_FIELD_W) begin : g_pad
      assign rdata_o = {{(CFG_W-CFG_FIELD_W){1'b0}}, cfg_to_bits(cfg_q)};
    end else begin : g_exact
      assign rdata_o = cfg_to_bits(cfg_q);
    end
  endgenerate

endmodule

// File: rtl/trace_ts_presc.sv
module trace_ts_presc
  import trace_ts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       clr_i,
  input  logic [1:0] presc_i,
  output logic       tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_last;

  assign div_last = presc_last(presc_i);
  assign tick_o   = active_i && (div_q == div_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           div_q <= '0;
    else if (!active_i || clr_i || tick_o) div_q <= '0;
    else                                   div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/trace_ts_cnt.sv
module trace_ts_cnt #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned IDLE_LIMIT = 2000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             bus_mode_i,
  input  logic             tick_i,
  input  logic             emit_i,
  input  logic             activity_i,
  output logic [CNT_W-1:0] delta_o,
  output logic             delta_max_o,
  output logic             idle_hit_o
);

  localparam int unsigned IDLE_W = (IDLE_LIMIT > 1) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_LIMIT - 1);

  logic [CNT_W-1:0]  delta_q;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  delta_q <= '0;
    else if (!active_i || emit_i) delta_q <= '0;
    else if (tick_i)              delta_q <= delta_q + 1'b1;
  end

  // idle time counts only where an idle emission is possible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           idle_q <= '0;
    else if (!active_i || emit_i || bus_mode_i || activity_i) idle_q <= '0;
    else                                                   idle_q <= idle_q + 1'b1;
  end

  assign delta_o     = delta_q;
  assign delta_max_o = &delta_q;
  assign idle_hit_o  = active_i && !bus_mode_i && (idle_q == IDLE_LAST);

endmodule

// File: rtl/trace_ts_emit.sv
module trace_ts_emit #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DRAIN_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             trace_en_i,
  input  logic             bus_mode_i,
  input  logic             pkt_wr_i,
  input  logic             bus_act_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] delta_i,
  input  logic             delta_max_i,
  input  logic             idle_hit_i,
  output logic             emit_o,
  output logic             activity_o,
  output logic             ts_valid_o,
  output logic [CNT_W-1:0] ts_delta_o,
  output logic             ts_ovf_o,
  output logic             busy_o
);

  localparam int unsigned DRAIN_W = $clog2(DRAIN_CYC + 1);

  logic               ovf_hit;
  logic               trig_hit;
  logic               pkt_acc;
  logic               valid_q;
  logic               ovf_q;
  logic [CNT_W-1:0]   val_q;
  logic [DRAIN_W-1:0] drain_q;

  assign activity_o = bus_mode_i ? bus_act_i : pkt_wr_i;
  assign ovf_hit    = tick_i && delta_max_i;
  assign trig_hit   = active_i && activity_o && (delta_i != '0);
  assign emit_o     = ovf_hit || trig_hit || idle_hit_i;
  assign pkt_acc    = trace_en_i && pkt_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      val_q   <= '0;
    end else begin
      valid_q <= emit_o;
      ovf_q   <= ovf_hit;
      if (emit_o) val_q <= ovf_hit ? '1 : delta_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               drain_q <= '0;
    else if (pkt_acc || emit_o) drain_q <= DRAIN_W'(DRAIN_CYC);
    else if (drain_q != '0)    drain_q <= drain_q - 1'b1;
  end

  assign ts_valid_o = valid_q;
  assign ts_ovf_o   = ovf_q;
  assign ts_delta_o = valid_q ? val_q : '0;
  assign busy_o     = (drain_q != '0);

endmodule

// File: rtl/trace_ts_gen.sv
module trace_ts_gen
  import trace_ts_pkg::*;
#(
  parameter int unsigned CFG_W      = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned IDLE_LIMIT = 2000000,
  parameter int unsigned DRAIN_CYC  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_priv_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             pkt_wr_i,
  input  logic             bus_act_i,
  output logic             ts_valid_o,
  output logic [CNT_W-1:0] ts_delta_o,
  output logic             ts_ovf_o,
  output logic             busy_o
);

  cfg_t             cfg;
  logic             presc_clr;
  logic             active;
  logic             trace_en;
  logic             tick;
  logic             emit;
  logic             activity;
  logic [CNT_W-1:0] delta;
  logic             delta_max;
  logic             idle_hit;

  assign trace_en = cfg.trace_en;
  assign active   = cfg.trace_en && cfg.ts_en;

  trace_ts_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .priv_i      (cfg_priv_i),
    .wdata_i     (cfg_wdata_i),
    .cfg_o       (cfg),
    .rdata_o     (cfg_rdata_o),
    .presc_clr_o (presc_clr)
  );

  trace_ts_presc u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .clr_i    (emit || presc_clr),
    .presc_i  (cfg.presc),
    .tick_o   (tick)
  );

  trace_ts_cnt #(.CNT_W(CNT_W), .IDLE_LIMIT(IDLE_LIMIT)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .bus_mode_i  (cfg.bus_mode),
    .tick_i      (tick),
    .emit_i      (emit),
    .activity_i  (activity),
    .delta_o     (delta),
    .delta_max_o (delta_max),
    .idle_hit_o  (idle_hit)
  );

  trace_ts_emit #(.CNT_W(CNT_W), .DRAIN_CYC(DRAIN_CYC)) u_emit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .trace_en_i  (trace_en),
    .bus_mode_i  (cfg.bus_mode),
    .pkt_wr_i    (pkt_wr_i),
    .bus_act_i   (bus_act_i),
    .tick_i      (tick),
    .delta_i     (delta),
    .delta_max_i (delta_max),
    .idle_hit_i  (idle_hit),
    .emit_o      (emit),
    .activity_o  (activity),
    .ts_valid_o  (ts_valid_o),
    .ts_delta_o  (ts_delta_o),
    .ts_ovf_o    (ts_ovf_o),
    .busy_o      (busy_o)
  );

endmodule

// File: rtl/trace_ts_chk.sv
module trace_ts_chk #(
  parameter int unsigned CFG_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             cfg_priv_i,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             pkt_wr_i,
  input logic             trace_en,
  input logic             active,
  input logic             ts_valid_o,
  input logic [CNT_W-1:0] ts_delta_o,
  input logic             ts_ovf_o,
  input logic             busy_o
);

  assert_priv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_priv_i) |=> $stable(cfg_rdata_o));

  assert_ovf_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_ovf_o |-> (ts_valid_o && (ts_delta_o == '1)));

  assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !ts_valid_o);

  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |=> !ts_valid_o);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_wr_i && trace_en) |=> busy_o);

endmodule

bind trace_ts_gen trace_ts_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_priv_i  (cfg_priv_i),
  .cfg_rdata_o (cfg_rdata_o),
  .pkt_wr_i    (pkt_wr_i),
  .trace_en    (trace_en),
  .active      (active),
  .ts_valid_o  (ts_valid_o),
  .ts_delta_o  (ts_delta_o),
  .ts_ovf_o    (ts_ovf_o),
  .busy_o      (busy_o)
);

// File: tb/trace_ts_gen_tb.sv
module trace_ts_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W      = 8;
  localparam int CNT_W      = 8;
  localparam int IDLE       = 400;
  localparam int DRAIN      = 3;
  localparam int MAXV       = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_priv = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [CFG_W-1:0] cfg_rdata;
  logic             pkt_wr = 1'b0;
  logic             bus_act = 1'b0;
  logic             ts_valid;
  logic [CNT_W-1:0] ts_delta;
  logic             ts_ovf;
  logic             busy;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ts_gen #(.CFG_W(CFG_W), .CNT_W(CNT_W), .IDLE_LIMIT(IDLE), .DRAIN_CYC(DRAIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .pkt_wr_i(pkt_wr),
    .bus_act_i(bus_act), .ts_valid_o(ts_valid), .ts_delta_o(ts_delta),
    .ts_ovf_o(ts_ovf), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // requirement model
  bit       m_te, m_tse, m_bm;
  bit [1:0] m_ps;
  int       m_div, m_delta, m_idle, m_drain;
  bit       m_valid, m_ovf;
  int       m_val;

  function automatic int rd_model();
    return int'(m_te) | (int'(m_tse) << 1) | (int'(m_bm) << 2) | (int'(m_ps) << 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_te, m_tse, m_bm, m_ps} = '0;
      m_div = 0; m_delta = 0; m_idle = 0; m_drain = 0;
      m_valid = 0; m_ovf = 0; m_val = 0;
    end else begin
      bit act, tick, ovf, trin, trig, ihit, emit, wr, pchg;
      act  = m_te && m_tse;
      tick = act && (m_div == (1 << (2*m_ps)) - 1);
      ovf  = tick && (m_delta == MAXV);
      trin = m_bm ? bus_act : pkt_wr;
      trig = act && trin && (m_delta != 0);
      ihit = act && !m_bm && (m_idle == IDLE - 1);
      emit = ovf || trig || ihit;
      wr   = cfg_we && cfg_priv;
      pchg = wr && (cfg_wdata[5:4] != m_ps);
      m_valid = emit;
      m_ovf   = ovf;
      m_val   = emit ? (ovf ? MAXV : m_delta) : 0;
      if (m_te && pkt_wr || emit) m_drain = DRAIN;
      else if (m_drain != 0) m_drain--;
      if (!act || emit) m_idle = 0;
      else if (m_bm || trin) m_idle = 0;
      else m_idle++;
      if (!act || emit) m_delta = 0;
      else if (tick) m_delta++;
      if (!act || emit || pchg || tick) m_div = 0;
      else m_div++;
      if (wr) {m_ps, m_bm, m_tse, m_te} = {cfg_wdata[5:4], cfg_wdata[2:0]};
    end
  end

  // cycle-by-cycle compare, covers R3 R4 R5 R6 R7 R9 R10 R11
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ts_valid == m_valid, "R4 model valid", ts_valid, m_valid);
      chk(int'(ts_delta) == m_val, "R3 model delta", ts_delta, m_val);
      chk(ts_ovf == m_ovf, "R5 model ovf", ts_ovf, m_ovf);
      chk(busy == (m_drain != 0), "R11 model busy", busy, m_drain != 0);
      chk(int'(cfg_rdata) == rd_model(), "R2 model readback", cfg_rdata, rd_model());
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cfg_write(input int data, input bit priv);
    cfg_we = 1'b1; cfg_priv = priv; cfg_wdata = CFG_W'(data);
    step(1);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!ts_valid && n < 3000) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, cnt;
    void'($urandom(32'h5eed_71ac));
    step(3);
    chk(cfg_rdata == 0 && !ts_valid && ts_delta == 0 && !ts_ovf && !busy,
        "R1 reset outputs", {cfg_rdata, ts_valid, ts_ovf, busy}, 0);
    rst_n = 1'b1;
    step(1);

    // R2 privilege and field layout
    cfg_write(8'h33, 1'b0);
    step(1);
    chk(cfg_rdata == 0, "R2 unprivileged write ignored", cfg_rdata, 0);
    cfg_write(8'hFF, 1'b1);
    chk(cfg_rdata == 8'h37, "R2 field layout", cfg_rdata, 8'h37);
    cfg_write(8'h00, 1'b1);

    // R8 trace on, timestamps off; R11 busy
    cfg_write(8'h31, 1'b1);
    pkt_wr = 1'b1; step(1); pkt_wr = 1'b0;
    for (int i = 0; i < DRAIN; i++) begin
      chk(busy, "R11 busy while draining", busy, 1);
      step(1);
    end
    chk(!busy, "R11 busy released", busy, 0);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      pkt_wr = (i % 7 == 0);
      step(1);
      if (ts_valid) cnt++;
    end
    pkt_wr = 1'b0;
    chk(cnt == 0, "R8 no emission when disabled", cnt, 0);

    // R4 zero-count packet, then count of one; R9 restart
    cfg_write(8'h00, 1'b1);
    cfg_write(8'h03, 1'b1);
    pkt_wr = 1'b1; step(1);
    chk(!ts_valid, "R4 zero count no emission", ts_valid, 0);
    step(1); pkt_wr = 1'b0;
    chk(ts_valid && ts_delta == 1, "R4 emission carries count", ts_delta, 1);
    step(1);
    chk(!ts_valid, "R9 single pulse", ts_valid, 0);

    // R5 overflow at prescale 0
    cfg_write(8'h00, 1'b1);
    cfg_write(8'h03, 1'b1);
    wait_valid(n);
    chk(ts_ovf == 1, "R5 overflow flag", ts_ovf, 1);
    chk(ts_delta == MAXV, "R5 saturated value", ts_delta, MAXV);
    chk(n == MAXV + 1, "R5 overflow time", n, MAXV + 1);

    // R3 and R6 idle emission under prescale codes 1..3
    for (int c = 1; c < 4; c++) begin
      cfg_write(8'h00, 1'b1);
      cfg_write((c << 4) | 3, 1'b1);
      wait_valid(n);
      chk(int'(ts_delta) == (IDLE - 1) / (1 << (2*c)), "R3 prescaled count", ts_delta,
          (IDLE - 1) / (1 << (2*c)));
      chk(!ts_ovf, "R6 idle emission not overflow", ts_ovf, 0);
      step(1);
      wait_valid(n);
      chk(n == IDLE - 1, "R6 idle interval", n + 1, IDLE);
    end

    // R10 prescale change clears divider
    cfg_write(8'h00, 1'b1);
    cfg_write(8'h33, 1'b1);
    step(50);
    cfg_write(8'h03, 1'b1);
    step(5);
    pkt_wr = 1'b1; step(1); pkt_wr = 1'b0;
    chk(ts_valid && ts_delta == 5, "R10 new ratio after change", ts_delta, 5);

    // R7 bus-activity mode
    cfg_write(8'h00, 1'b1);
    cfg_write(8'h37, 1'b1);
    cnt = 0;
    for (int i = 0; i < 700; i++) begin
      pkt_wr = (i % 9 == 0);
      step(1);
      if (ts_valid) cnt++;
    end
    pkt_wr = 1'b0;
    chk(cnt == 0, "R7 packets and idle ignored", cnt, 0);
    bus_act = 1'b1; step(1); bus_act = 1'b0;
    chk(ts_valid && !ts_ovf && ts_delta == 700 / 64, "R7 bus activity emits", ts_delta, 700 / 64);

    // random mix against model
    for (int i = 0; i < 6000; i++) begin
      pkt_wr  = ($urandom_range(7) == 0);
      bus_act = ($urandom_range(7) == 0);
      if ($urandom_range(150) == 0) begin
        int d;
        d = ($urandom_range(3) << 4) | (($urandom_range(3) == 0) << 2) |
            (($urandom_range(3) != 0) << 1) | ($urandom_range(7) != 0);
        cfg_we = 1'b1; cfg_priv = ($urandom_range(7) != 0); cfg_wdata = CFG_W'(d);
      end else begin
        cfg_we = 1'b0; cfg_priv = 1'b0;
      end
      step(1);
    end
    cfg_we = 1'b0; pkt_wr = 1'b0; bus_act = 1'b0;
    step(2);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule